// File: doc/BRIEF.md
# Command Effects Log Builder

After reset this block walks every opcode in a configurable command space, with the command set as the outer index and the command as the inner index. For each opcode it asks a neighbouring lookup whether that opcode is supported and what its effects are. Each supported opcode is appended to an internal log as one 4-byte entry. Once the walk is over, the block serves two host queries over a byte-stream response port. The first is a supported-logs query that describes the single log it holds. The second is a get-log query that returns a byte slice of the log.

States: `ST_BUILD` (walk in progress, queries held off), `ST_IDLE` (ready for a query), `ST_SUPP` (streaming the 28-byte supported-logs response), `ST_SLICE` (streaming a log slice) and `ST_FINISH` (one-cycle completion). The transitions are:
- BUILD to IDLE when the walk ends.
- IDLE to SUPP on a supported-logs query.
- IDLE to SLICE on a get-log query that is valid and not empty.
- IDLE to FINISH on a rejected or empty get-log query.
- SUPP or SLICE to FINISH on the last byte.
- FINISH to IDLE.

Top module: `cel_builder`

## Requirements
- R1: The walk visits opcodes `{set[7:0], cmd[7:0]}` in ascending order, for sets 0..NUM_SETS-1 and commands 0..NUM_CMDS-1. Each opcode with `probe_hit` high adds one entry, in walk order. Entry k occupies log bytes 4k..4k+3 as opcode low byte, opcode high byte, effects low byte, effects high byte.
- R2: `ready` stays low from reset until the walk completes. It rises NUM_SETS*NUM_CMDS+1 clock edges after reset is released.
- R3: A supported-logs query (`q_kind`=0) streams 28 bytes and completes with status 0x00 and length 28. The bytes are: bytes 0..1 hold the count 1 (little-endian), bytes 2..7 are zero, bytes 8..23 hold LOG_ID with its low byte first, and bytes 24..27 hold 4 times the entry count (little-endian).
- R4: A get-log query (`q_kind`=1) where offset+length, computed without wrap, exceeds PAYLOAD_BYTES completes with status 0x02, length 0 and no data bytes.
- R5: A get-log query that is in range but whose `q_id` differs from LOG_ID completes with status 0x03, length 0 and no data bytes.
- R6: The range check takes priority over the identifier check: a query that fails both reports 0x02.
- R7: A valid get-log query streams `q_length` bytes taken from log byte `q_offset` onward, and completes with status 0x00 and length `q_length`. Log bytes past the last built entry read as zero.
- R8: `rsp_last` is high only on the final data byte. `cpl_valid` is a single-cycle pulse in the cycle after that byte.
- R9: `q_valid` has no effect while `ready` is low: no byte and no completion appears during the walk.
- R10: During reset `ready`, `rsp_valid` and `cpl_valid` are all low.
- R11: Only effects bits 1 (configuration change), 2 (data change), 3 (policy change) and 4 (log change) are stored. All other effects bits are stored as zero.
- R12: A valid get-log query of length 0 completes with status 0x00, length 0 and no data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_opcode | output | 16 | Opcode being examined by the walk |
| probe_hit | input | 1 | Lookup result: opcode supported |
| probe_effects | input | 16 | Lookup result: effects mask |
| ready | output | 1 | Block accepts a query this cycle |
| q_valid | input | 1 | Query present |
| q_kind | input | 1 | 0 = supported-logs, 1 = get-log |
| q_id | input | 128 | Log identifier for get-log |
| q_offset | input | 32 | Byte offset for get-log |
| q_length | input | 32 | Byte count for get-log |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |
| cpl_valid | output | 1 | Completion pulse |
| cpl_status | output | 8 | Completion status code |
| cpl_len | output | 16 | Response length in bytes |

## Verification
The assertions assume the lookup behind `probe_hit` answers combinationally for the opcode currently on `probe_opcode`. They also assume it reports no more supported opcodes than PAYLOAD_BYTES/4 entries can hold. The bench's lookup model marks twelve opcodes in a 16-entry store, so it stays within that bound. Queries are raised only at a falling edge and dropped one cycle later. A query is never held across a completion, except for the deliberate hold during the walk.

// File: rtl/cel_pkg.sv
package cel_pkg;
    typedef enum logic [2:0] {
        ST_BUILD,
        ST_IDLE,
        ST_SUPP,
        ST_SLICE,
        ST_FINISH
    } cel_state_e;

    localparam logic [7:0]  RC_OK        = 8'h00;
    localparam logic [7:0]  RC_BAD_INPUT = 8'h02;
    localparam logic [7:0]  RC_NOT_SUPP  = 8'h03;
    localparam int          SUPP_BYTES   = 28;
    localparam logic [15:0] EFFECT_KEEP  = 16'h001E;
endpackage

// File: rtl/cel_scan.sv
module cel_scan #(
    parameter int NUM_SETS = 256,
    parameter int NUM_CMDS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        busy,
    output logic [15:0] probe_opcode
);
    logic [7:0] set_q;
    logic [7:0] cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            cmd_q <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (cmd_q == 8'(NUM_CMDS - 1)) begin
                cmd_q <= '0;
                if (set_q == 8'(NUM_SETS - 1)) busy <= 1'b0;
                else set_q <= set_q + 8'd1;
            end else begin
                cmd_q <= cmd_q + 8'd1;
            end
        end
    end

    assign probe_opcode = {set_q, cmd_q};

    // R1: opcodes are examined in strictly ascending order
    p_ascending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || probe_opcode > $past(probe_opcode)));
endmodule

// File: rtl/cel_store.sv
module cel_store #(
    parameter int DEPTH = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [31:0]                     wr_word,
    input  logic [$clog2(DEPTH)+1:0]        rd_addr,
    output logic [7:0]                      rd_byte,
    output logic [$clog2(DEPTH+1)-1:0]      count
);
    localparam int IW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [31:0]   mem [DEPTH];
    logic [IW-1:0] rd_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en && count < CNTW'(DEPTH)) begin
            count <= count + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && count < CNTW'(DEPTH)) mem[count[IW-1:0]] <= wr_word;
    end

    assign rd_idx = rd_addr[IW+1:2];

    always_comb begin
        if (CNTW'(rd_idx) < count) rd_byte = mem[rd_idx][{rd_addr[1:0], 3'b000} +: 8];
        else rd_byte = 8'h00;
    end

    // R1: every supported opcode finds a free entry
    p_entry_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> count < CNTW'(DEPTH));
endmodule

// File: rtl/cel_builder.sv
module cel_builder
    import cel_pkg::*;
#(
    parameter int           NUM_SETS      = 256,
    parameter int           NUM_CMDS      = 256,
    parameter int           PAYLOAD_BYTES = 256,
    parameter logic [127:0] LOG_ID        = 128'h173F3B62_B196798F_784B41BF_B5C0A90D
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [15:0]  probe_opcode,
    input  logic         probe_hit,
    input  logic [15:0]  probe_effects,
    output logic         ready,
    input  logic         q_valid,
    input  logic         q_kind,
    input  logic [127:0] q_id,
    input  logic [31:0]  q_offset,
    input  logic [31:0]  q_length,
    output logic         rsp_valid,
    output logic [7:0]   rsp_data,
    output logic         rsp_last,
    output logic         cpl_valid,
    output logic [7:0]   cpl_status,
    output logic [15:0]  cpl_len
);
    localparam int DEPTH = PAYLOAD_BYTES / 4;
    localparam int AW    = $clog2(DEPTH) + 2;
    localparam int CNTW  = $clog2(DEPTH + 1);

    cel_state_e      state_q, state_d;
    logic [15:0]     pos_q, pos_d, len_q, len_d, olen_q, olen_d;
    logic [7:0]      st_q, st_d;
    logic [AW-1:0]   base_q, base_d;
    logic            scan_busy;
    logic [CNTW-1:0] n_entries;
    logic [AW-1:0]   rd_addr;
    logic [7:0]      rd_byte;
    logic [7:0]      supp_byte;
    logic [15:0]     rel8, rel24;
    logic [31:0]     log_size;
    logic            range_bad, id_bad, at_last;

    cel_scan #(.NUM_SETS(NUM_SETS), .NUM_CMDS(NUM_CMDS)) i_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (scan_busy),
        .probe_opcode (probe_opcode)
    );

    cel_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (scan_busy && probe_hit),
        .wr_word ({probe_effects & EFFECT_KEEP, probe_opcode}),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte),
        .count   (n_entries)
    );

    assign range_bad = ({1'b0, q_offset} + {1'b0, q_length}) > 33'(PAYLOAD_BYTES);
    assign id_bad    = (q_id != LOG_ID);
    assign rd_addr   = base_q + pos_q[AW-1:0];
    assign at_last   = (state_q == ST_SUPP  && pos_q == 16'(SUPP_BYTES - 1)) ||
                       (state_q == ST_SLICE && pos_q == len_q - 16'd1);

    // supported-logs response image
    assign rel8     = pos_q - 16'd8;
    assign rel24    = pos_q - 16'd24;
    assign log_size = 32'(n_entries) << 2;
    always_comb begin
        if (pos_q == 16'd0)       supp_byte = 8'h01;
        else if (pos_q < 16'd8)   supp_byte = 8'h00;
        else if (pos_q < 16'd24)  supp_byte = LOG_ID[{rel8[3:0], 3'b000} +: 8];
        else                      supp_byte = log_size[{rel24[1:0], 3'b000} +: 8];
    end

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        len_d   = len_q;
        olen_d  = olen_q;
        st_d    = st_q;
        base_d  = base_q;
        unique case (state_q)
            ST_BUILD: if (!scan_busy) state_d = ST_IDLE;
            ST_IDLE: begin
                if (q_valid) begin
                    pos_d  = '0;
                    st_d   = RC_OK;
                    olen_d = '0;
                    if (!q_kind) begin
                        state_d = ST_SUPP;
                        olen_d  = 16'(SUPP_BYTES);
                    end else if (range_bad) begin
                        state_d = ST_FINISH;
                        st_d    = RC_BAD_INPUT;
                    end else if (id_bad) begin
                        state_d = ST_FINISH;
                        st_d    = RC_NOT_SUPP;
                    end else if (q_length == 32'd0) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_SLICE;
                        base_d  = q_offset[AW-1:0];
                        len_d   = q_length[15:0];
                        olen_d  = q_length[15:0];
                    end
                end
            end
            ST_SUPP, ST_SLICE: begin
                pos_d = pos_q + 16'd1;
                if (at_last) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_BUILD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BUILD;
            pos_q   <= '0;
            len_q   <= '0;
            olen_q  <= '0;
            st_q    <= RC_OK;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            len_q   <= len_d;
            olen_q  <= olen_d;
            st_q    <= st_d;
            base_q  <= base_d;
        end
    end

    // outputs
    always_comb begin
        ready      = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_SUPP) || (state_q == ST_SLICE);
        rsp_data   = 8'h00;
        if (state_q == ST_SUPP)  rsp_data = supp_byte;
        if (state_q == ST_SLICE) rsp_data = rd_byte;
        rsp_last   = at_last;
        cpl_valid  = (state_q == ST_FINISH);
        cpl_status = cpl_valid ? st_q : 8'h00;
        cpl_len    = cpl_valid ? olen_q : 16'h0000;
    end

    // R8: final-byte marker only on a valid byte
    p_last_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);
    // R8: completion follows the final byte
    p_cpl_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |=> cpl_valid);
    // R8: completion is a single-cycle pulse
    p_cpl_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);
    // R4: error completions carry no data
    p_err_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status != RC_OK) |-> cpl_len == 16'd0);
    // R9: nothing leaves the block while the walk runs
    p_walk_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> (!rsp_valid && !cpl_valid && !ready));
endmodule

// File: tb/test_cel_builder.sv
module test_cel_builder;
    localparam int NSETS = 8;
    localparam int NCMDS = 16;
    localparam int PBYTES = 64;
    localparam logic [127:0] ID = 128'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F90;

    typedef struct packed {
        logic        good_id;
        logic [31:0] off;
        logic [31:0] len;
        logic [7:0]  st;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 32'd0,          32'd48, 8'h00},  // R1 R11 R7 full log
        '{1'b1, 32'd4,          32'd8,  8'h00},  // R7 aligned slice
        '{1'b1, 32'd3,          32'd5,  8'h00},  // R7 unaligned slice
        '{1'b1, 32'd40,         32'd24, 8'h00},  // R7 reaches buffer end, tail zero
        '{1'b1, 32'd41,         32'd24, 8'h02},  // R4 one past end
        '{1'b0, 32'd8,          32'd4,  8'h03},  // R5 wrong id
        '{1'b0, 32'd60,         32'd8,  8'h02},  // R6 both wrong
        '{1'b1, 32'd10,         32'd0,  8'h00},  // R12 empty slice
        '{1'b1, 32'hFFFF_FFF0,  32'h20, 8'h02}   // R4 no wrap
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] probe_opcode, probe_effects;
    logic probe_hit;
    logic ready, q_valid = 1'b0, q_kind = 1'b0;
    logic [127:0] q_id = '0;
    logic [31:0] q_offset = '0, q_length = '0;
    logic rsp_valid, rsp_last, cpl_valid;
    logic [7:0] rsp_data, cpl_status;
    logic [15:0] cpl_len;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] exp_log [PBYTES];
    logic [7:0] got [128];
    int got_n, last_at;
    logic [7:0] got_st;
    logic [15:0] got_len;

    always #5 clk = ~clk;

    cel_builder #(.NUM_SETS(NSETS), .NUM_CMDS(NCMDS), .PAYLOAD_BYTES(PBYTES), .LOG_ID(ID)) i_cel_builder (
        .clk(clk), .rst_n(rst_n), .probe_opcode(probe_opcode), .probe_hit(probe_hit),
        .probe_effects(probe_effects), .ready(ready), .q_valid(q_valid), .q_kind(q_kind),
        .q_id(q_id), .q_offset(q_offset), .q_length(q_length), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_len(cpl_len)
    );

    function automatic logic sup(input logic [7:0] s, input logic [7:0] c);
        return (s == 1 && c < 4) || (s == 3 && c < 2) || (s == 4 && c < 2) ||
               (s == 5 && c == 0) || (s == 6 && (c == 0 || c == 2 || c == 3));
    endfunction

    function automatic logic [15:0] eff(input logic [7:0] s, input logic [7:0] c);
        if (s == 1 && c == 1) return 16'h0010;
        if (s == 1 && c == 3) return 16'h0003;
        if (s == 3 && c == 1) return 16'h0008;
        if (s == 6 && c == 3) return 16'h0006;
        if (s == 6 && c == 2) return 16'hFFFF;
        return 16'h0000;
    endfunction

    assign probe_hit     = sup(probe_opcode[15:8], probe_opcode[7:0]);
    assign probe_effects = eff(probe_opcode[15:8], probe_opcode[7:0]);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic query(input logic kind, input logic [127:0] id,
                         input logic [31:0] off, input logic [31:0] len);
        @(negedge clk);
        q_valid = 1'b1; q_kind = kind; q_id = id; q_offset = off; q_length = len;
        @(negedge clk);
        q_valid = 1'b0;
        got_n = 0; last_at = -1;
        for (int t = 0; t < 200; t++) begin
            if (cpl_valid) break;
            if (rsp_valid) begin
                got[got_n] = rsp_data;
                if (rsp_last) last_at = got_n;
                got_n++;
            end
            @(negedge clk);
        end
        got_st = cpl_status; got_len = cpl_len;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n, k, mism;
        logic [15:0] op, ef;
        for (int b = 0; b < PBYTES; b++) exp_log[b] = 8'h00;
        k = 0;
        for (int s = 0; s < NSETS; s++)
            for (int c = 0; c < NCMDS; c++)
                if (sup(8'(s), 8'(c))) begin
                    op = {8'(s), 8'(c)};
                    ef = eff(8'(s), 8'(c)) & 16'h001E;
                    exp_log[4*k] = op[7:0]; exp_log[4*k+1] = op[15:8];
                    exp_log[4*k+2] = ef[7:0]; exp_log[4*k+3] = ef[15:8];
                    k++;
                end

        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R10 ready", int'(ready), 0);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", int'(rsp_valid), 0);
        chk(cpl_valid == 1'b0, "R10 cpl_valid", int'(cpl_valid), 0);

        // query held during the walk must do nothing
        q_valid = 1'b1; q_kind = 1'b0;
        rst_n = 1'b1;
        n = 0; mism = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
            if (rsp_valid || cpl_valid) mism++;
        end
        q_valid = 1'b0;
        chk(n == NSETS * NCMDS + 1, "R2 ready latency", n, NSETS * NCMDS + 1);
        chk(mism == 0, "R9 activity during walk", mism, 0);
        @(negedge clk);
        chk(!rsp_valid && !cpl_valid, "R9 no late response", int'(rsp_valid), 0);

        // supported-logs query
        query(1'b0, '0, '0, '0);
        chk(got_st == 8'h00 && got_len == 16'd28, "R3 completion", int'(got_len), 28);
        chk(got_n == 28 && last_at == 27, "R3 R8 framing", got_n, 28);
        mism = 0;
        for (int b = 0; b < 28; b++) begin
            logic [7:0] e;
            if (b == 0) e = 8'h01;
            else if (b < 8) e = 8'h00;
            else if (b < 24) e = ID[8*(b-8) +: 8];
            else e = 8'((4 * k) >> (8 * (b - 24)));
            if (got[b] !== e) mism++;
        end
        chk(mism == 0, "R3 response bytes", mism, 0);

        // get-log vector table
        for (int v = 0; v < 9; v++) begin
            query(1'b1, VECS[v].good_id ? ID : (ID ^ 128'h1), VECS[v].off, VECS[v].len);
            chk(got_st == VECS[v].st, "R4 R5 R6 R7 status", int'(got_st), int'(VECS[v].st));
            if (VECS[v].st == 8'h00) begin
                chk(got_len == VECS[v].len[15:0], "R7 R12 length", int'(got_len), int'(VECS[v].len));
                chk(got_n == int'(VECS[v].len), "R7 R12 byte count", got_n, int'(VECS[v].len));
                chk(last_at == got_n - 1, "R8 last marker", last_at, got_n - 1);
                mism = 0;
                for (int b = 0; b < got_n; b++)
                    if (got[b] !== exp_log[int'(VECS[v].off) + b]) mism++;
                chk(mism == 0, "R1 R7 R11 slice bytes", mism, 0);
            end else begin
                chk(got_len == 16'd0 && got_n == 0, "R4 R5 R6 empty on error", got_n, 0);
            end
        end

        @(negedge clk);
        chk(ready && !cpl_valid, "R8 return to idle", int'(ready), 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule